// File: doc/BRIEF.md
# Loop Configuration Fetch Sequencer

This block steers an array coprocessor through one software-pipelined loop. While the host CPU is idle, a single invocation pulse hands the block four values: the first configuration address of the loop kernel, the initiation interval (how many configuration slots make up one kernel pass), the number of pipeline stages, and the trip count. After a fixed two-cycle handover, the block reads one wide configuration word per cycle from a synchronous configuration memory. It walks the kernel slots in order and wraps back to the first one. Each word goes to the array together with a per-stage predicate mask.

The kernel repeats once per "wave", and a new iteration enters every initiation interval. There are trip count plus stages minus one waves. The mask switches off stages that hold no live iteration, which happens in the prologue and the epilogue. When the last slot has been shown, the block pulses `done`, takes two cycles to give control back, and releases the host. A stall input freezes the whole sequencer in place. The host and the array never run at the same time: `hostHold` marks the span during which the host must wait.

Top module: `loop_cfg_sequencer`

## Requirements
- R1: After reset, `hostHold`, `cfgRdEn`, `arrCfgValid` and `done` are low, and `arrStageMask` is zero.
- R2: An invocation is taken only when `invoke` is high in a cycle where the block is idle and `stall` is low. At that edge it captures `invStart`, `invIi`, `invStages` and `invTrips`. An invocation raised while `hostHold` is high, or while `stall` is high, has no effect.
- R3: If the invocation is sampled at edge 0, `hostHold` is high from cycle 1. No configuration read is issued in cycles 1 and 2, and the first read, at address `invStart`, is issued in cycle 3.
- R4: Read k (counting from 0) uses address (`invStart` + k mod II) mod 128, so addresses are 7 bits wide. Reads are issued one per unstalled cycle. The word read is presented on `arrCfg` with `arrCfgValid` high in the cycle after the read.
- R5: A run with a non-zero trip count presents exactly (trips + stages − 1) × II words.
- R6: For word k, let w = floor(k / II). Bit s of `arrStageMask` is 1 exactly when s < stages, s ≤ w and w − s < trips. Stage 0 is bit 0.
- R7: `done` is high for one cycle, in the cycle right after the last presented word. `hostHold` stays high for that cycle and one more, then falls. Without stalls, `hostHold` is high for 5 + N cycles, where N is the word count.
- R8: While `stall` is high, `cfgRdEn` and `arrCfgValid` are low and `cfgRdAddr` holds its value. Each stall cycle lengthens the run by exactly one cycle and does not alter the word or mask sequence.
- R9: A trip count of zero presents no words. It still performs both handovers, so `hostHold` is high for 5 cycles and `done` pulses once.
- R10: An II or stage count of zero is treated as 1. A stage count above STAGE_MAX (8) is treated as STAGE_MAX.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| invoke | input | 1 | Invocation request from the host |
| invStart | input | 7 | First kernel configuration address |
| invIi | input | 4 | Initiation interval (kernel slots) |
| invStages | input | 4 | Pipeline stage count |
| invTrips | input | 8 | Loop trip count |
| stall | input | 1 | Freeze request |
| cfgRdAddr | output | 7 | Configuration memory read address |
| cfgRdEn | output | 1 | Configuration memory read enable |
| cfgRdData | input | 32 | Configuration word from memory (one-cycle latency) |
| arrCfg | output | 32 | Configuration word presented to the array |
| arrCfgValid | output | 1 | Presented word is live this cycle |
| arrStageMask | output | 8 | Per-stage predicate for the presented word |
| hostHold | output | 1 | Array owns control; host waits |
| done | output | 1 | Loop finished pulse |

## Verification
The bench goes after the edges of the pipelined schedule. A short prologue (one stage) and a long one (stage count clamped to eight) both appear. A design that sized the mask from the wave number alone would enable dead stages in the epilogue. A kernel starting near address 127 shows whether the addresses wrap modulo 128 or run into the next region. A stall held in mid-run catches a counter that keeps moving while frozen, which would drop or repeat words. A zero trip count and zero II or stage values catch a sequencer that would hang or fetch forever. A stray invocation during a run catches a design that reloads its parameters in mid-loop.

// File: rtl/lcfs_pkg.sv
package lcfs_pkg;

  typedef enum logic [2:0] {
    SEQ_IDLE,
    SEQ_ENTER,
    SEQ_FETCH,
    SEQ_FLUSH,
    SEQ_EXIT
  } seqState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic load;    // capture invocation parameters, clear counters
    logic fetch;   // issue one configuration read and advance counters
    logic freeze;  // hold presentation stage
  } seqStrobe_t;

endpackage

// File: rtl/lcfs_ctrl.sv
module lcfs_ctrl
  import lcfs_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       invoke,
  input  logic       stall,
  input  logic       lastFetch,
  input  logic       zeroTrip,
  output seqStrobe_t strobe,
  output logic       hostHold,
  output logic       done
);

  seqState_e stateQ, stateD;
  logic      hsQ;  // second cycle of a two-cycle handover

  always_comb begin
    stateD        = stateQ;
    strobe        = '0;
    strobe.freeze = stall;
    unique case (stateQ)
      SEQ_IDLE: begin
        if (invoke && !stall) begin
          strobe.load = 1'b1;
          stateD      = SEQ_ENTER;
        end
      end
      SEQ_ENTER: begin
        if (!stall && hsQ) stateD = zeroTrip ? SEQ_FLUSH : SEQ_FETCH;
      end
      SEQ_FETCH: begin
        if (!stall) begin
          strobe.fetch = 1'b1;
          if (lastFetch) stateD = SEQ_FLUSH;
        end
      end
      SEQ_FLUSH: begin
        if (!stall) stateD = SEQ_EXIT;
      end
      SEQ_EXIT: begin
        if (!stall && hsQ) stateD = SEQ_IDLE;
      end
      default: stateD = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= SEQ_IDLE;
      hsQ    <= 1'b0;
    end else if (!stall) begin
      stateQ <= stateD;
      hsQ    <= (stateQ == SEQ_ENTER || stateQ == SEQ_EXIT) ? ~hsQ : 1'b0;
    end
  end

  assign hostHold = (stateQ != SEQ_IDLE);
  assign done     = (stateQ == SEQ_EXIT) && !hsQ && !stall;

endmodule

// File: rtl/lcfs_datapath.sv
module lcfs_datapath
  import lcfs_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int CFG_W     = 32,
  parameter int STAGE_MAX = 8,
  parameter int II_W      = 4,
  parameter int TRIP_W    = 8,
  localparam int STG_W    = $clog2(STAGE_MAX + 1),
  localparam int WAVE_W   = TRIP_W + 1
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  seqStrobe_t           strobe,
  input  logic [ADDR_W-1:0]    invStart,
  input  logic [II_W-1:0]      invIi,
  input  logic [STG_W-1:0]     invStages,
  input  logic [TRIP_W-1:0]    invTrips,
  input  logic [CFG_W-1:0]     cfgRdData,
  output logic                 lastFetch,
  output logic                 zeroTrip,
  output logic [ADDR_W-1:0]    cfgRdAddr,
  output logic                 cfgRdEn,
  output logic [CFG_W-1:0]     arrCfg,
  output logic                 arrCfgValid,
  output logic [STAGE_MAX-1:0] arrStageMask
);

  logic [ADDR_W-1:0]    startQ;
  logic [II_W-1:0]      iiQ, iiEff, slotQ;
  logic [STG_W-1:0]     stagesQ, stgEff;
  logic [TRIP_W-1:0]    tripsQ;
  logic [WAVE_W-1:0]    wavesQ, wavesD, waveQ;
  logic [STAGE_MAX-1:0] liveMask, maskQ;
  logic                 presQ;
  logic                 slotWrap;

  // Parameter sanitising at capture time
  always_comb begin
    iiEff = (invIi == '0) ? II_W'(1) : invIi;
    if (invStages == '0)                    stgEff = STG_W'(1);
    else if (invStages > STG_W'(STAGE_MAX)) stgEff = STG_W'(STAGE_MAX);
    else                                    stgEff = invStages;
    wavesD = WAVE_W'(invTrips) + WAVE_W'(stgEff) - WAVE_W'(1);
  end

  assign slotWrap  = (slotQ == iiQ - II_W'(1));
  assign lastFetch = slotWrap && (waveQ == wavesQ - WAVE_W'(1));
  assign zeroTrip  = (tripsQ == '0);

  // Parameter and counter registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      startQ  <= '0;
      iiQ     <= II_W'(1);
      stagesQ <= STG_W'(1);
      tripsQ  <= '0;
      wavesQ  <= '0;
      slotQ   <= '0;
      waveQ   <= '0;
    end else if (strobe.load) begin
      startQ  <= invStart;
      iiQ     <= iiEff;
      stagesQ <= stgEff;
      tripsQ  <= invTrips;
      wavesQ  <= wavesD;
      slotQ   <= '0;
      waveQ   <= '0;
    end else if (strobe.fetch) begin
      if (slotWrap) begin
        slotQ <= '0;
        waveQ <= waveQ + WAVE_W'(1);
      end else begin
        slotQ <= slotQ + II_W'(1);
      end
    end
  end

  // Address wraps naturally modulo the memory depth
  assign cfgRdAddr = startQ + ADDR_W'(slotQ);
  assign cfgRdEn   = strobe.fetch;

  // Stage liveness: stage s carries iteration (wave - s)
  for (genvar s = 0; s < STAGE_MAX; s++) begin : g_stage
    logic inRange, started, notRetired;
    assign inRange    = (STG_W'(s) < stagesQ);
    assign started    = (waveQ >= WAVE_W'(s));
    assign notRetired = ((waveQ - WAVE_W'(s)) < WAVE_W'(tripsQ));
    assign liveMask[s] = inRange && started && notRetired;
  end

  // Presentation stage aligned with memory read latency
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presQ <= 1'b0;
      maskQ <= '0;
    end else if (!strobe.freeze) begin
      presQ <= strobe.fetch;
      maskQ <= strobe.fetch ? liveMask : '0;
    end
  end

  assign arrCfg       = cfgRdData;
  assign arrCfgValid  = presQ && !strobe.freeze;
  assign arrStageMask = arrCfgValid ? maskQ : '0;

endmodule

// File: rtl/loop_cfg_sequencer.sv
module loop_cfg_sequencer
  import lcfs_pkg::*;
#(
  parameter int ADDR_W    = 7,
  parameter int CFG_W     = 32,
  parameter int STAGE_MAX = 8,
  parameter int II_W      = 4,
  parameter int TRIP_W    = 8,
  localparam int STG_W    = $clog2(STAGE_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 invoke,
  input  logic [ADDR_W-1:0]    invStart,
  input  logic [II_W-1:0]      invIi,
  input  logic [STG_W-1:0]     invStages,
  input  logic [TRIP_W-1:0]    invTrips,
  input  logic                 stall,
  output logic [ADDR_W-1:0]    cfgRdAddr,
  output logic                 cfgRdEn,
  input  logic [CFG_W-1:0]     cfgRdData,
  output logic [CFG_W-1:0]     arrCfg,
  output logic                 arrCfgValid,
  output logic [STAGE_MAX-1:0] arrStageMask,
  output logic                 hostHold,
  output logic                 done
);

  seqStrobe_t strobe;
  logic       lastFetch, zeroTrip;

  lcfs_ctrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .invoke    (invoke),
    .stall     (stall),
    .lastFetch (lastFetch),
    .zeroTrip  (zeroTrip),
    .strobe    (strobe),
    .hostHold  (hostHold),
    .done      (done)
  );

  lcfs_datapath #(
    .ADDR_W    (ADDR_W),
    .CFG_W     (CFG_W),
    .STAGE_MAX (STAGE_MAX),
    .II_W      (II_W),
    .TRIP_W    (TRIP_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .invStart     (invStart),
    .invIi        (invIi),
    .invStages    (invStages),
    .invTrips     (invTrips),
    .cfgRdData    (cfgRdData),
    .lastFetch    (lastFetch),
    .zeroTrip     (zeroTrip),
    .cfgRdAddr    (cfgRdAddr),
    .cfgRdEn      (cfgRdEn),
    .arrCfg       (arrCfg),
    .arrCfgValid  (arrCfgValid),
    .arrStageMask (arrStageMask)
  );

endmodule

// File: rtl/lcfs_checker.sv
module lcfs_checker #(
  parameter int ADDR_W    = 7,
  parameter int STAGE_MAX = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 stall,
  input logic                 cfgRdEn,
  input logic [ADDR_W-1:0]    cfgRdAddr,
  input logic                 arrCfgValid,
  input logic [STAGE_MAX-1:0] arrStageMask,
  input logic                 hostHold,
  input logic                 done
);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !hostHold |-> (!cfgRdEn && !arrCfgValid && !done));

  assert_entry_first_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostHold) |-> !cfgRdEn);

  assert_entry_second_R3: assert property (@(posedge clk) disable iff (!rstN)
    ($rose(hostHold) && !stall) |=> !cfgRdEn);

  assert_valid_in_run_R4: assert property (@(posedge clk) disable iff (!rstN)
    arrCfgValid |-> hostHold);

  assert_mask_live_R6: assert property (@(posedge clk) disable iff (!rstN)
    arrCfgValid |-> (arrStageMask != '0));

  assert_done_single_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  assert_done_handback_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> hostHold);

  assert_stall_noread_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |-> !cfgRdEn);

  assert_stall_addr_R8: assert property (@(posedge clk) disable iff (!rstN)
    stall |=> $stable(cfgRdAddr));

endmodule

bind loop_cfg_sequencer lcfs_checker #(
  .ADDR_W    (ADDR_W),
  .STAGE_MAX (STAGE_MAX)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .stall        (stall),
  .cfgRdEn      (cfgRdEn),
  .cfgRdAddr    (cfgRdAddr),
  .arrCfgValid  (arrCfgValid),
  .arrStageMask (arrStageMask),
  .hostHold     (hostHold),
  .done         (done)
);

// File: tb/loop_cfg_sequencer_tb.sv
module loop_cfg_sequencer_tb;

  localparam int ADDR_W    = 7;
  localparam int CFG_W     = 32;
  localparam int STAGE_MAX = 8;
  localparam int II_W      = 4;
  localparam int TRIP_W    = 8;
  localparam int STG_W     = $clog2(STAGE_MAX + 1);

  typedef struct packed {
    logic [CFG_W-1:0]     word;
    logic [STAGE_MAX-1:0] mask;
  } expItem_t;

  logic                 clk = 1'b0;
  logic                 rstN = 1'b0;
  logic                 invoke = 1'b0;
  logic [ADDR_W-1:0]    invStart = '0;
  logic [II_W-1:0]      invIi = '0;
  logic [STG_W-1:0]     invStages = '0;
  logic [TRIP_W-1:0]    invTrips = '0;
  logic                 stall = 1'b0;
  logic [ADDR_W-1:0]    cfgRdAddr;
  logic                 cfgRdEn;
  logic [CFG_W-1:0]     cfgRdData = '0;
  logic [CFG_W-1:0]     arrCfg;
  logic                 arrCfgValid;
  logic [STAGE_MAX-1:0] arrStageMask;
  logic                 hostHold;
  logic                 done;

  int vecCnt = 0;
  int errCnt = 0;
  int cyc = 0;
  int lastPresCyc = 0;
  int doneCyc = 0;
  int doneCnt = 0;
  expItem_t expQ[$];

  always #4 clk = ~clk;  // 125 MHz
  always @(posedge clk) cyc <= cyc + 1;

  loop_cfg_sequencer u_dut (
    .clk          (clk),
    .rstN         (rstN),
    .invoke       (invoke),
    .invStart     (invStart),
    .invIi        (invIi),
    .invStages    (invStages),
    .invTrips     (invTrips),
    .stall        (stall),
    .cfgRdAddr    (cfgRdAddr),
    .cfgRdEn      (cfgRdEn),
    .cfgRdData    (cfgRdData),
    .arrCfg       (arrCfg),
    .arrCfgValid  (arrCfgValid),
    .arrStageMask (arrStageMask),
    .hostHold     (hostHold),
    .done         (done)
  );

  function automatic logic [CFG_W-1:0] cfgWord(input int a);
    logic [7:0] lo;
    lo = 8'(a);
    return {lo ^ 8'hA5, 8'(a * 3 + 1), ~lo, lo};
  endfunction

  // Synchronous configuration memory, contents computed from the address
  always @(posedge clk) if (cfgRdEn) cfgRdData <= cfgWord(int'(cfgRdAddr));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    vecCnt++;
    if (!ok) begin
      errCnt++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [STAGE_MAX-1:0] expMask(input int w, input int stg, input int trips);
    logic [STAGE_MAX-1:0] m;
    m = '0;
    for (int s = 0; s < STAGE_MAX; s++)
      m[s] = (s < stg) && (w >= s) && (w - s < trips);
    return m;
  endfunction

  // Monitor: pops the scoreboard as words are presented
  always @(negedge clk) begin
    if (rstN) begin
      if (arrCfgValid) begin
        lastPresCyc = cyc;
        if (expQ.size() == 0) begin
          check(1'b0, "R5 extra word", longint'(arrCfg), 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          check(arrCfg == e.word, "R4 word", longint'(arrCfg), longint'(e.word));
          check(arrStageMask == e.mask, "R6 mask", longint'(arrStageMask), longint'(e.mask));
        end
        if (stall) check(1'b0, "R8 valid under stall", 1, 0);
      end
      if (done) begin
        doneCnt++;
        doneCyc = cyc;
      end
    end
  end

  // Driver: one loop invocation, with optional mid-run stall and stray invoke
  task automatic runLoop(input int start, input int ii, input int stg, input int trips,
                         input int stallAt, input int stallLen, input bit stray,
                         input string tag);
    int iiE, stgE, waves, n, holdCnt;
    iiE  = (ii == 0) ? 1 : ii;
    stgE = (stg == 0) ? 1 : ((stg > STAGE_MAX) ? STAGE_MAX : stg);
    waves = trips + stgE - 1;
    n = (trips == 0) ? 0 : waves * iiE;
    for (int k = 0; k < n; k++) begin
      expItem_t e;
      e.word = cfgWord((start + (k % iiE)) % 128);
      e.mask = expMask(k / iiE, stgE, trips);
      expQ.push_back(e);
    end
    doneCnt = 0;
    @(negedge clk);
    invStart = ADDR_W'(start); invIi = II_W'(ii);
    invStages = STG_W'(stg); invTrips = TRIP_W'(trips);
    invoke = 1'b1;
    @(negedge clk);
    invoke = 1'b0;
    holdCnt = 0;
    while (hostHold) begin
      holdCnt++;
      if (holdCnt <= 2) check(!cfgRdEn, {tag, " R3 no read in entry"}, cfgRdEn, 0);
      if (holdCnt == 3 && n > 0 && stallAt > 3) begin
        check(cfgRdEn, {tag, " R3 first read"}, cfgRdEn, 1);
        check(cfgRdAddr == ADDR_W'(start), {tag, " R3 first addr"}, cfgRdAddr, start);
      end
      if (stallLen > 0 && holdCnt == stallAt) stall = 1'b1;
      if (stallLen > 0 && holdCnt == stallAt + stallLen) stall = 1'b0;
      if (stray && holdCnt == 4) begin
        invStart = 7'd99; invIi = 4'd7; invStages = 4'd2; invTrips = 8'd9; invoke = 1'b1;
      end
      if (stray && holdCnt == 5) invoke = 1'b0;
      @(negedge clk);
    end
    check(holdCnt == 5 + n + stallLen, {tag, " R7 hold length"}, holdCnt, 5 + n + stallLen);
    check(expQ.size() == 0, {tag, " R5 words missing"}, expQ.size(), 0);
    check(doneCnt == 1, {tag, " R7 done count"}, doneCnt, 1);
    if (n > 0) check(doneCyc == lastPresCyc + 1, {tag, " R7 done timing"}, doneCyc - lastPresCyc, 1);
    expQ.delete();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errCnt++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!hostHold && !cfgRdEn && !arrCfgValid && !done && arrStageMask == '0,
          "R1 reset outputs", {hostHold, cfgRdEn, arrCfgValid, done}, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    check(!hostHold && !done, "R1 idle after reset", {hostHold, done}, 0);

    runLoop(10, 2, 3, 4, 99, 0, 1'b0, "base");       // R5 N=12
    runLoop(20, 2, 4, 4, 99, 0, 1'b0, "deeper");     // R5 N=14
    runLoop(125, 5, 2, 3, 99, 0, 1'b0, "wrap");      // R4 address wrap
    runLoop(0, 3, 3, 5, 6, 3, 1'b0, "stall");        // R8
    runLoop(40, 1, 1, 6, 99, 0, 1'b1, "stray");      // R2 invoke while busy
    runLoop(60, 3, 2, 0, 99, 0, 1'b0, "zerotrip");   // R9
    runLoop(70, 0, 0, 3, 99, 0, 1'b0, "zeroparm");   // R10 zero treated as 1
    runLoop(5, 1, 12, 2, 99, 0, 1'b0, "clamp");      // R10 stage clamp

    // R2: invocation during stall is not taken
    @(negedge clk);
    stall = 1'b1; invoke = 1'b1;
    @(negedge clk);
    invoke = 1'b0;
    @(negedge clk);
    check(!hostHold, "R2 invoke under stall ignored", hostHold, 0);
    stall = 1'b0;
    repeat (2) @(negedge clk);
    check(!hostHold && !cfgRdEn, "R2 still idle", {hostHold, cfgRdEn}, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule